// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides when a small processor core stops its normal instruction stream to take an exception, and which exception it takes. It arbitrates between three classes of event: the reset class, interrupt requests and trap instructions. The reset class comes from a rising reset pin or a watchdog overflow. The core reports two kinds of event to the block. One is an instruction-boundary strobe, with a flag for instructions that change flags or control registers. The other is an end-of-sequence strobe for the exception routine entry. The block answers with a single-cycle start pulse, a class code and the vector-table address that the core fetches its start address from.

A three-state machine tracks the mode: held in reset, executing, or inside an exception-entry sequence. Interrupts are masked at two points. They are not taken at the boundary of a flag or control-register instruction. They are also refused from reset exception handling until the core pulses an explicit enable, for instance after it has set up its stack pointer. Trap instructions are never masked.

Top module: `exc_entry_seq`

## Requirements
- R1: While `res_n` is low, `cpu_state` is 0 (reset), `exc_start` stays low, and interrupt, trap and watchdog inputs have no effect.
- R2: At the first rising clock edge that samples `res_n` high after it was low, a reset exception starts. In the next cycle `exc_start` is 1, `exc_class` is 1, `exc_vaddr` is 0 and `cpu_state` is 2 (exception).
- R3: A `wdt_ovf` sampled high while `res_n` is high starts a reset exception (class 1, address 0) in the next cycle. This takes priority over any interrupt or trap sampled on the same edge.
- R4: After any reset exception, interrupts are refused at every boundary until `irq_enable` has been sampled high.
- R5: An enabled, pending `irq_req` is taken only when `insn_end` is sampled in state 1 (executing), or when `seq_end` is sampled in state 2. The exception then starts in the next cycle with class 2 and address 2 × `irq_vec`.
- R6: An `insn_end` sampled together with `insn_nomask` accepts no interrupt. The request waits for the next boundary.
- R7: A `trap_exec` sampled in state 1 starts a trap exception whether interrupts are enabled or not. It has class 3 and address 8 + 2 × `trap_num`.
- R8: When an interrupt and a trap qualify on the same edge, the interrupt is taken (class 2).
- R9: `exc_start` lasts exactly one cycle. The block stays in state 2 until a `seq_end` is sampled after the start cycle. It then enters state 1 in the next cycle, unless an interrupt is taken at that point.
- R10: A `trap_exec` sampled outside state 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low, sampled on clk |
| wdt_ovf | input | 1 | Watchdog overflow request |
| irq_req | input | 1 | Interrupt request pending |
| irq_vec | input | VEC_W | Vector number supplied with the request |
| irq_enable | input | 1 | Pulse that lifts the post-reset interrupt disable |
| insn_end | input | 1 | Current instruction completes this cycle |
| insn_nomask | input | 1 | Completing instruction is of a flag/control-modifying kind |
| seq_end | input | 1 | Exception-entry sequence completes this cycle |
| trap_exec | input | 1 | Trap instruction executes this cycle |
| trap_num | input | TRAP_W | Trap number |
| exc_start | output | 1 | Single-cycle exception start pulse |
| exc_class | output | 2 | 0 none, 1 reset, 2 interrupt, 3 trap |
| exc_vaddr | output | ADDR_W | Vector-table address of the taken exception |
| cpu_state | output | 2 | 0 reset, 1 executing, 2 exception sequence |

## Verification
The assertions assume that the core never raises `seq_end` outside an exception sequence. They also assume that `res_n` is low on the first clock edge, so that the edge detector starts from a known value. The directed tasks follow the core's protocol. Each scenario begins with a full reset pulse. Each drives `seq_end` only while the block reports state 2, and drives boundary and trap strobes only in state 1, except where a task deliberately tests that a strobe in the wrong state is ignored.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int VEC_W     = 6,
  parameter int TRAP_W    = 2,
  parameter int ADDR_W    = 16,
  parameter int TRAP_BASE = 8
) (
  input  logic              clk,
  input  logic              res_n,
  input  logic              wdt_ovf,
  input  logic              irq_req,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_enable,
  input  logic              insn_end,
  input  logic              insn_nomask,
  input  logic              seq_end,
  input  logic              trap_exec,
  input  logic [TRAP_W-1:0] trap_num,
  output logic              exc_start,
  output logic [1:0]        exc_class,
  output logic [ADDR_W-1:0] exc_vaddr,
  output logic [1:0]        cpu_state
);
  localparam logic [1:0] ST_RESET = 2'd0, ST_EXEC = 2'd1, ST_EXC = 2'd2;
  localparam logic [1:0] CL_NONE = 2'd0, CL_RST = 2'd1, CL_IRQ = 2'd2, CL_TRAP = 2'd3;

  logic res_q, int_en_q;

  wire seq_done  = (cpu_state == ST_EXC) && seq_end && !exc_start;
  wire boundary  = ((cpu_state == ST_EXEC) && insn_end && !insn_nomask) || seq_done;
  wire take_rst  = res_n && (!res_q || wdt_ovf);
  wire take_irq  = irq_req && int_en_q && boundary;
  wire take_trap = (cpu_state == ST_EXEC) && trap_exec;

  wire [ADDR_W-1:0] irq_addr  = ADDR_W'(irq_vec) << 1;
  wire [ADDR_W-1:0] trap_addr = ADDR_W'(TRAP_BASE) + (ADDR_W'(trap_num) << 1);

  always_ff @(posedge clk) begin
    res_q <= res_n;
    if (!res_n) begin
      cpu_state <= ST_RESET;
      exc_start <= 1'b0;
      exc_class <= CL_NONE;
      exc_vaddr <= '0;
      int_en_q  <= 1'b0;
    end else begin
      exc_start <= 1'b0;
      if (irq_enable) int_en_q <= 1'b1;
      if (take_rst) begin
        cpu_state <= ST_EXC;
        exc_start <= 1'b1;
        exc_class <= CL_RST;
        exc_vaddr <= '0;
        int_en_q  <= 1'b0;
      end else if (take_irq) begin
        cpu_state <= ST_EXC;
        exc_start <= 1'b1;
        exc_class <= CL_IRQ;
        exc_vaddr <= irq_addr;
      end else if (take_trap) begin
        cpu_state <= ST_EXC;
        exc_start <= 1'b1;
        exc_class <= CL_TRAP;
        exc_vaddr <= trap_addr;
      end else if (seq_done) begin
        cpu_state <= ST_EXEC;
      end
    end
  end
endmodule

module exc_entry_seq_chk #(
  parameter int ADDR_W    = 16,
  parameter int TRAP_W    = 2,
  parameter int TRAP_BASE = 8
) (
  input logic              clk,
  input logic              res_n,
  input logic              insn_end,
  input logic              seq_end,
  input logic              exc_start,
  input logic [1:0]        exc_class,
  input logic [ADDR_W-1:0] exc_vaddr,
  input logic [1:0]        cpu_state
);
  localparam int TRAP_TOP = TRAP_BASE + 2 * ((1 << TRAP_W) - 1);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_hold_in_reset_r1: assert property (@(posedge clk) disable iff (!armed)
    !res_n |=> (!exc_start && cpu_state == 2'd0));
  p_reset_vector_r2: assert property (@(posedge clk) disable iff (!res_n)
    (exc_start && exc_class == 2'd1) |-> exc_vaddr == '0);
  p_irq_at_boundary_r5: assert property (@(posedge clk) disable iff (!res_n)
    (exc_start && exc_class == 2'd2) |-> ($past(insn_end) || $past(seq_end)));
  p_trap_vector_r7: assert property (@(posedge clk) disable iff (!res_n)
    (exc_start && exc_class == 2'd3) |->
      (!exc_vaddr[0] && exc_vaddr >= ADDR_W'(TRAP_BASE) && exc_vaddr <= ADDR_W'(TRAP_TOP)));
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!res_n)
    exc_start |=> !exc_start);
  p_start_in_exc_r9: assert property (@(posedge clk) disable iff (!res_n)
    exc_start |-> (cpu_state == 2'd2 && exc_class != 2'd0));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W), .TRAP_W(TRAP_W), .TRAP_BASE(TRAP_BASE)) u_chk (
  .clk(clk), .res_n(res_n), .insn_end(insn_end), .seq_end(seq_end),
  .exc_start(exc_start), .exc_class(exc_class), .exc_vaddr(exc_vaddr), .cpu_state(cpu_state));

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic res_n = 1'b0, wdt_ovf = 1'b0, irq_req = 1'b0, irq_enable = 1'b0;
  logic insn_end = 1'b0, insn_nomask = 1'b0, seq_end = 1'b0, trap_exec = 1'b0;
  logic [5:0]  irq_vec = '0;
  logic [1:0]  trap_num = '0;
  logic        exc_start;
  logic [1:0]  exc_class, cpu_state;
  logic [15:0] exc_vaddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_enable(irq_enable), .insn_end(insn_end), .insn_nomask(insn_nomask),
    .seq_end(seq_end), .trap_exec(trap_exec), .trap_num(trap_num),
    .exc_start(exc_start), .exc_class(exc_class), .exc_vaddr(exc_vaddr), .cpu_state(cpu_state));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    wdt_ovf = 0; irq_req = 0; irq_enable = 0; insn_end = 0;
    insn_nomask = 0; seq_end = 0; trap_exec = 0;
  endtask

  task automatic expect_start(input string req, input int cls, input int addr);
    chk({req, " start"}, int'(exc_start), 1);
    chk({req, " class"}, int'(exc_class), cls);
    chk({req, " addr"}, int'(exc_vaddr), addr);
    chk({req, " state"}, int'(cpu_state), 2);
  endtask

  task automatic finish_seq();
    idle(); tick();
    seq_end = 1; tick(); seq_end = 0;
  endtask

  task automatic boot();
    idle(); res_n = 0; tick(); tick();
    res_n = 1; tick();
    finish_seq();
  endtask

  task automatic t_reset();
    idle(); res_n = 0; tick();
    irq_req = 1; trap_exec = 1; wdt_ovf = 1; insn_end = 1; tick(); tick();
    chk("R1 no start while held", int'(exc_start), 0);
    chk("R1 state reset", int'(cpu_state), 0);
    idle(); res_n = 1; tick();
    expect_start("R2", 1, 0);
    tick();
    chk("R9 pulse one cycle", int'(exc_start), 0);
    chk("R9 held in exc", int'(cpu_state), 2);
    seq_end = 1; tick(); seq_end = 0;
    chk("R9 back to exec", int'(cpu_state), 1);
  endtask

  task automatic t_mask_after_reset();
    boot();
    irq_req = 1; irq_vec = 6'd5; insn_end = 1; tick(); tick();
    chk("R4 irq refused before enable", int'(exc_start), 0);
    insn_end = 0; irq_enable = 1; tick(); irq_enable = 0;
    chk("R4 no start on enable", int'(exc_start), 0);
    insn_end = 1; tick();
    expect_start("R4 irq after enable", 2, 10);
    finish_seq();
  endtask

  task automatic t_boundary();
    boot(); irq_enable = 1; tick(); irq_enable = 0;
    irq_req = 1; irq_vec = 6'd63; tick(); tick();
    chk("R5 not taken mid-instruction", int'(exc_start), 0);
    insn_end = 1; insn_nomask = 1; tick();
    chk("R6 deferred after flag insn", int'(exc_start), 0);
    insn_nomask = 0; tick();
    expect_start("R5 irq at insn end", 2, 126);
    insn_end = 0; irq_vec = 6'd7; tick();
    seq_end = 1; tick(); seq_end = 0;
    expect_start("R5 irq at seq end", 2, 14);
    irq_req = 0; finish_seq();
    chk("R9 exec after seq", int'(cpu_state), 1);
  endtask

  task automatic t_trap();
    boot();
    trap_exec = 1; trap_num = 2'd3; tick(); trap_exec = 0;
    expect_start("R7 trap while masked", 3, 14);
    trap_exec = 1; trap_num = 2'd0; tick(); tick();
    chk("R10 trap in exc ignored", int'(exc_start), 0);
    chk("R10 state exc", int'(cpu_state), 2);
    trap_exec = 0; seq_end = 1; tick(); seq_end = 0;
    trap_num = 2'd1; trap_exec = 1; tick(); trap_exec = 0;
    expect_start("R7 trap 1", 3, 10);
    finish_seq();
  endtask

  task automatic t_priority();
    boot(); irq_enable = 1; tick(); irq_enable = 0;
    irq_req = 1; irq_vec = 6'd3; insn_end = 1; trap_exec = 1; trap_num = 2'd2; tick();
    idle();
    expect_start("R8 irq beats trap", 2, 6);
    finish_seq();
    irq_req = 1; insn_end = 1; trap_exec = 1; wdt_ovf = 1; tick();
    idle();
    expect_start("R3 watchdog wins", 1, 0);
    finish_seq();
    irq_req = 1; insn_end = 1; tick(); tick();
    chk("R4 masked after watchdog reset", int'(exc_start), 0);
    idle();
  endtask

  initial begin
    t_reset();
    t_mask_after_reset();
    t_boundary();
    t_trap();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule